// File: doc/BRIEF.md
# Secondary Interrupt Controller with Passthrough Lines

This block gathers a bank of level-sensitive interrupt sources behind a primary interrupt controller. Each source's level is captured every cycle into a raw status vector, a software-programmable enable mask selects which sources may raise a request, and the OR of all enabled, active sources becomes one combined request. That request is placed on a chosen line of a vector that connects to the primary controller's inputs.

A contiguous group of sources can also bypass the combining logic. Each of them has its own passthrough-enable bit; when the bit is set, the source's raw level appears on the matching line of the upstream vector, so the primary controller can see and prioritise it directly. A stored software-interrupt bit is merged into source 0, so firmware can raise and withdraw an interrupt of its own.

Software programs the block over a small word-addressed register bus with separate read and write strobes. Enable registers use set and clear write semantics, so no read-modify-write is needed. Read data is registered and reflects the state before any write in the same cycle.

Top module: `sec_irq_ctrl`

## Requirements
- R1: On every clock edge the level of each input `irq_i[k]` is captured; raw status is this captured vector with bit 0 additionally ORed with the software pending bit, and a read of index 1 (byte address bits [11:2] equal 1) returns it.
- R2: A read of index 0 returns raw status ANDed with the enable mask.
- R3: A write to index 2 ORs the write data into the enable mask; a read of index 2 returns the enable mask.
- R4: A write to index 3 clears every enable bit that is 1 in the write data and leaves the others unchanged.
- R5: A nonzero write to index 4 sets the software pending bit and a nonzero write to index 5 clears it; a zero write to either has no effect; a read of index 4 returns raw status bit 0 in bit 0 and zero in bits 31:1.
- R6: A write to index 8 ORs write data bits 30:21 into the passthrough enable and ignores all other bits; a write to index 9 clears the passthrough bits that are 1 in the write data; a read of index 8 returns the passthrough enable at bits 30:21 with all other bits zero.
- R7: `comb_irq_o` is 1 exactly when raw status ANDed with the enable mask is nonzero, and the same value is ORed onto `upstream_irq_o[COMB_IDX]` (default 31); both are registered and follow an input or register change by one cycle.
- R8: For each source k from 21 to 30, `upstream_irq_o[k]` equals raw status bit k when passthrough bit k is set and 0 when it is clear; every other upstream line except `COMB_IDX` is 0; these outputs are registered like R7.
- R9: Only byte address bits [11:2] select a register; bits [1:0] are ignored. Reads of any index other than 0, 1, 2, 4 and 8 return 0, writes to any index other than 2, 3, 4, 5, 8 and 9 change nothing, `bus_rdata_o` is 0 in a cycle after no read, and a read returns the state before a same-cycle write.
- R10: After reset, raw status, enable mask, software pending bit, passthrough enable, read data and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_SRC | Level-sensitive interrupt sources |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte address within the register window |
| bus_wdata_i | input | NUM_SRC | Write data |
| bus_rdata_o | output | NUM_SRC | Registered read data, valid the cycle after a read strobe |
| comb_irq_o | output | 1 | Combined request of all enabled active sources |
| upstream_irq_o | output | NUM_SRC | Lines to the primary controller: passthrough lines plus the combined request at COMB_IDX |

## Verification
The bench builds the block with its default parameters: 32 sources, passthrough lines 21 to 30, the combined request on line 31 and a 12-bit byte address. With only ten index bits, every one of the 1024 register indices is read and written in turn with random low address bits, and one-hot walks cover every source, enable bit and passthrough bit on its own. A long stretch of random reads, writes and input patterns then compares read data and all upstream lines against an arithmetic model in every cycle, including same-cycle read and write of one register.

// File: rtl/sic_pkg.sv
package sic_pkg;

    // Register indices (byte offset divided by four)
    localparam int unsigned IDX_MASKED = 0;
    localparam int unsigned IDX_RAW    = 1;
    localparam int unsigned IDX_EN_SET = 2;
    localparam int unsigned IDX_EN_CLR = 3;
    localparam int unsigned IDX_SW_SET = 4;
    localparam int unsigned IDX_SW_CLR = 5;
    localparam int unsigned IDX_PT_SET = 8;
    localparam int unsigned IDX_PT_CLR = 9;

    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic sw_set;
        logic sw_clr;
        logic pt_set;
        logic pt_clr;
    } wr_strobe_t;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_MASKED,
        RSEL_RAW,
        RSEL_EN,
        RSEL_SW,
        RSEL_PT
    } rd_sel_t;

endpackage

// File: rtl/sic_addr_dec.sv
module sic_addr_dec
    import sic_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    output wr_strobe_t        wr_stb_o,
    output rd_sel_t           rd_sel_o
);
    localparam int unsigned IW = ADDR_W - 2;

    logic [IW-1:0] idx;
    logic          addr_lo_unused;

    assign idx            = addr_i[ADDR_W-1:2];
    assign addr_lo_unused = ^addr_i[1:0];

    always_comb begin
        wr_stb_o = '0;
        if (wr_i) begin
            case (idx)
                IW'(IDX_EN_SET): wr_stb_o.en_set = 1'b1;
                IW'(IDX_EN_CLR): wr_stb_o.en_clr = 1'b1;
                IW'(IDX_SW_SET): wr_stb_o.sw_set = 1'b1;
                IW'(IDX_SW_CLR): wr_stb_o.sw_clr = 1'b1;
                IW'(IDX_PT_SET): wr_stb_o.pt_set = 1'b1;
                IW'(IDX_PT_CLR): wr_stb_o.pt_clr = 1'b1;
                default:         wr_stb_o = '0;
            endcase
        end
    end

    always_comb begin
        rd_sel_o = RSEL_NONE;
        if (rd_i) begin
            case (idx)
                IW'(IDX_MASKED): rd_sel_o = RSEL_MASKED;
                IW'(IDX_RAW):    rd_sel_o = RSEL_RAW;
                IW'(IDX_EN_SET): rd_sel_o = RSEL_EN;
                IW'(IDX_SW_SET): rd_sel_o = RSEL_SW;
                IW'(IDX_PT_SET): rd_sel_o = RSEL_PT;
                default:         rd_sel_o = RSEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/sic_rd_mux.sv
module sic_rd_mux
    import sic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned PT_LO   = 21,
    parameter int unsigned PT_W    = 10
) (
    input  rd_sel_t              sel_i,
    input  logic [NUM_SRC-1:0]   raw_i,
    input  logic [NUM_SRC-1:0]   en_i,
    input  logic [PT_W-1:0]      pt_i,
    output logic [NUM_SRC-1:0]   data_o
);
    logic [NUM_SRC-1:0] pt_wide;

    assign pt_wide = {{(NUM_SRC-PT_W){1'b0}}, pt_i} << PT_LO;

    always_comb begin
        case (sel_i)
            RSEL_MASKED: data_o = raw_i & en_i;
            RSEL_RAW:    data_o = raw_i;
            RSEL_EN:     data_o = en_i;
            RSEL_SW:     data_o = {{(NUM_SRC-1){1'b0}}, raw_i[0]};
            RSEL_PT:     data_o = pt_wide;
            default:     data_o = '0;
        endcase
    end

endmodule

// File: rtl/sic_out_route.sv
module sic_out_route #(
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned PT_LO    = 21,
    parameter int unsigned PT_HI    = 30,
    parameter int unsigned COMB_IDX = 31,
    localparam int unsigned PT_W    = PT_HI - PT_LO + 1
) (
    input  logic [NUM_SRC-1:0] raw_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [PT_W-1:0]    pt_i,
    output logic               comb_o,
    output logic [NUM_SRC-1:0] up_o
);
    logic [NUM_SRC-1:0] pt_line;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_line
        if (k >= PT_LO && k <= PT_HI) begin : g_pass
            assign pt_line[k] = raw_i[k] & pt_i[k-PT_LO];
        end else begin : g_off
            assign pt_line[k] = 1'b0;
        end
    end

    assign comb_o = |(raw_i & en_i);

    always_comb begin
        up_o           = pt_line;
        up_o[COMB_IDX] = pt_line[COMB_IDX] | comb_o;
    end

endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
    import sic_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned PT_LO    = 21,
    parameter int unsigned PT_HI    = 30,
    parameter int unsigned COMB_IDX = 31
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [NUM_SRC-1:0] bus_wdata_i,
    output logic [NUM_SRC-1:0] bus_rdata_o,
    output logic               comb_irq_o,
    output logic [NUM_SRC-1:0] upstream_irq_o
);
    localparam int unsigned PT_W = PT_HI - PT_LO + 1;

    typedef struct packed {
        logic [NUM_SRC-1:0] lvl;
        logic               sw;
        logic [NUM_SRC-1:0] en;
        logic [PT_W-1:0]    pt;
    } reg_t;

    typedef struct packed {
        logic [NUM_SRC-1:0] rdata;
        logic               comb;
        logic [NUM_SRC-1:0] up;
    } out_t;

    reg_t st_d, st_q;
    out_t out_d, out_q;

    wr_strobe_t         wr_stb;
    rd_sel_t            rd_sel;
    logic [NUM_SRC-1:0] raw_q, raw_d;
    logic [NUM_SRC-1:0] rd_val;
    logic               comb_d;
    logic [NUM_SRC-1:0] up_d;

    // named views of the state for the bound checker
    logic [NUM_SRC-1:0] lvl_q, en_q;
    logic               sw_q;
    logic [PT_W-1:0]    pt_q;

    assign lvl_q = st_q.lvl;
    assign en_q  = st_q.en;
    assign sw_q  = st_q.sw;
    assign pt_q  = st_q.pt;

    sic_addr_dec #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .wr_i     (bus_wr_i),
        .rd_i     (bus_rd_i),
        .addr_i   (bus_addr_i),
        .wr_stb_o (wr_stb),
        .rd_sel_o (rd_sel)
    );

    assign raw_q = st_q.lvl | {{(NUM_SRC-1){1'b0}}, st_q.sw};
    assign raw_d = st_d.lvl | {{(NUM_SRC-1){1'b0}}, st_d.sw};

    sic_rd_mux #(
        .NUM_SRC (NUM_SRC),
        .PT_LO   (PT_LO),
        .PT_W    (PT_W)
    ) u_rd (
        .sel_i  (rd_sel),
        .raw_i  (raw_q),
        .en_i   (st_q.en),
        .pt_i   (st_q.pt),
        .data_o (rd_val)
    );

    sic_out_route #(
        .NUM_SRC  (NUM_SRC),
        .PT_LO    (PT_LO),
        .PT_HI    (PT_HI),
        .COMB_IDX (COMB_IDX)
    ) u_route (
        .raw_i  (raw_d),
        .en_i   (st_d.en),
        .pt_i   (st_d.pt),
        .comb_o (comb_d),
        .up_o   (up_d)
    );

    always_comb begin
        st_d     = st_q;
        st_d.lvl = irq_i;
        if (wr_stb.en_set) st_d.en = st_q.en | bus_wdata_i;
        if (wr_stb.en_clr) st_d.en = st_q.en & ~bus_wdata_i;
        if (wr_stb.sw_set && (|bus_wdata_i)) st_d.sw = 1'b1;
        if (wr_stb.sw_clr && (|bus_wdata_i)) st_d.sw = 1'b0;
        if (wr_stb.pt_set) st_d.pt = st_q.pt | bus_wdata_i[PT_HI:PT_LO];
        if (wr_stb.pt_clr) st_d.pt = st_q.pt & ~bus_wdata_i[PT_HI:PT_LO];

        out_d.rdata = rd_val;
        out_d.comb  = comb_d;
        out_d.up    = up_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= '0;
            out_q <= '0;
        end else begin
            st_q  <= st_d;
            out_q <= out_d;
        end
    end

    assign bus_rdata_o    = out_q.rdata;
    assign comb_irq_o     = out_q.comb;
    assign upstream_irq_o = out_q.up;

endmodule

// File: rtl/sec_irq_ctrl_chk.sv
module sec_irq_ctrl_chk #(
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned IW       = 10,
    parameter int unsigned PT_LO    = 21,
    parameter int unsigned PT_HI    = 30,
    parameter int unsigned COMB_IDX = 31,
    localparam int unsigned PT_W    = PT_HI - PT_LO + 1
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] irq_i,
    input logic               wr_i,
    input logic               rd_i,
    input logic [IW-1:0]      idx_i,
    input logic [NUM_SRC-1:0] wdata_i,
    input logic [NUM_SRC-1:0] rdata_i,
    input logic               comb_i,
    input logic [NUM_SRC-1:0] up_i,
    input logic [NUM_SRC-1:0] lvl_q,
    input logic               sw_q,
    input logic [NUM_SRC-1:0] en_q,
    input logic [PT_W-1:0]    pt_q
);
    logic [NUM_SRC-1:0] raw;
    logic               wr_known;

    assign raw      = lvl_q | {{(NUM_SRC-1){1'b0}}, sw_q};
    assign wr_known = (idx_i == IW'(2)) || (idx_i == IW'(3)) || (idx_i == IW'(4)) ||
                      (idx_i == IW'(5)) || (idx_i == IW'(8)) || (idx_i == IW'(9));

    p_lvl_track_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (lvl_q == $past(irq_i)));

    p_en_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && idx_i == IW'(2)) |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));

    p_en_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && idx_i == IW'(3)) |=> ((en_q & $past(wdata_i)) == '0));

    p_sw_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && idx_i == IW'(4) && (|wdata_i)) |=> sw_q);

    p_sw_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && idx_i == IW'(5) && (|wdata_i)) |=> !sw_q);

    p_sw_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && (idx_i == IW'(4) || idx_i == IW'(5)) && wdata_i == '0) |=> $stable(sw_q));

    p_comb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        comb_i == (|(raw & en_q)));

    p_comb_line_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        comb_i |-> up_i[COMB_IDX]);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_lines
        if (k != COMB_IDX && k >= PT_LO && k <= PT_HI) begin : g_pass
            p_pass_line_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                up_i[k] == (raw[k] & pt_q[k-PT_LO]));
        end else if (k != COMB_IDX) begin : g_quiet
            p_quiet_line_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                !up_i[k]);
        end
    end

    p_undef_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !wr_known) |=> ($stable(en_q) && $stable(pt_q) && $stable(sw_q)));

    p_rd_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> (rdata_i == '0));

endmodule

bind sec_irq_ctrl sec_irq_ctrl_chk #(
    .NUM_SRC  (NUM_SRC),
    .IW       (ADDR_W - 2),
    .PT_LO    (PT_LO),
    .PT_HI    (PT_HI),
    .COMB_IDX (COMB_IDX)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .irq_i   (irq_i),
    .wr_i    (bus_wr_i),
    .rd_i    (bus_rd_i),
    .idx_i   (bus_addr_i[ADDR_W-1:2]),
    .wdata_i (bus_wdata_i),
    .rdata_i (bus_rdata_o),
    .comb_i  (comb_irq_o),
    .up_i    (upstream_irq_o),
    .lvl_q   (lvl_q),
    .sw_q    (sw_q),
    .en_q    (en_q),
    .pt_q    (pt_q)
);

// File: tb/sec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sec_irq_ctrl_tb_top;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq   = '0;
    logic        wr    = 1'b0;
    logic        rd    = 1'b0;
    logic [11:0] addr  = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        comb;
    logic [31:0] up;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;
    bit done = 1'b0;

    // reference model state (after the most recent modelled edge)
    logic [31:0] m_lvl = '0;
    logic [31:0] m_en  = '0;
    logic [31:0] m_pt  = '0;
    logic        m_sw  = 1'b0;

    always #2 clk = ~clk;

    sec_irq_ctrl dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .irq_i          (irq),
        .bus_wr_i       (wr),
        .bus_rd_i       (rd),
        .bus_addr_i     (addr),
        .bus_wdata_i    (wdata),
        .bus_rdata_o    (rdata),
        .comb_irq_o     (comb),
        .upstream_irq_o (up)
    );

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt > 150000 && !done) begin
            done = 1'b1;
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_raw();
        return m_lvl | {31'b0, m_sw};
    endfunction

    function automatic logic [31:0] m_read(input int idx);
        case (idx)
            0:       return m_raw() & m_en;
            1:       return m_raw();
            2:       return m_en;
            4:       return {31'b0, m_raw() & 32'h1} ;
            8:       return m_pt;
            default: return 32'h0;
        endcase
    endfunction

    // one bus cycle: drive at falling edge, sample 1 ns after the rising edge
    task automatic cyc(input bit w, input bit r, input int idx, input logic [31:0] d,
                       input logic [31:0] iv, input string tag);
        logic [31:0] exp_rd;
        logic [31:0] raw;
        logic        exp_comb;
        @(negedge clk);
        wr    = w;
        rd    = r;
        addr  = {idx[9:0], 2'($urandom_range(3, 0))};
        wdata = d;
        irq   = iv;
        exp_rd = r ? m_read(idx) : 32'h0;
        m_lvl = iv;
        if (w) begin
            case (idx)
                2: m_en = m_en | d;
                3: m_en = m_en & ~d;
                4: if (d != 0) m_sw = 1'b1;
                5: if (d != 0) m_sw = 1'b0;
                8: m_pt = m_pt | (d & 32'h7FE0_0000);
                9: m_pt = m_pt & ~d;
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        raw      = m_raw();
        exp_comb = |(raw & m_en);
        check(rdata, exp_rd, r ? tag : "R9 idle read data");
        check({31'b0, comb}, {31'b0, exp_comb}, "R7 combined output");
        check(up, (raw & m_pt) | {exp_comb, 31'b0}, "R8 upstream lines");
    endtask

    task automatic idle(input logic [31:0] iv, input string tag);
        cyc(1'b0, 1'b0, 0, 32'h0, iv, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: outputs held at zero during reset
        check(up, 32'h0, "R10 reset upstream");
        check(rdata, 32'h0, "R10 reset read data");
        check({31'b0, comb}, 32'h0, "R10 reset combined");
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1, i, 32'h0, 32'h0, "R10 reset register");

        // R1: walk one source at a time, then all ones
        for (int i = 0; i < 32; i++) begin
            idle(32'h1 << i, "R1");
            cyc(1'b0, 1'b1, 1, 32'h0, 32'h0, "R1 raw one-hot");
        end
        idle(32'hFFFF_FFFF, "R1");
        cyc(1'b0, 1'b1, 1, 32'h0, 32'hFFFF_FFFF, "R1 raw all ones");

        // R3: enable set, bit by bit
        for (int i = 0; i < 32; i++) begin
            cyc(1'b1, 1'b0, 2, 32'h1 << i, 32'hFFFF_FFFF, "R3");
            cyc(1'b0, 1'b1, 2, 32'h0, 32'hFFFF_FFFF, "R3 enable after set");
        end
        // R4: enable clear, bit by bit
        for (int i = 0; i < 32; i++) begin
            cyc(1'b1, 1'b0, 3, 32'h1 << i, 32'h0, "R4");
            cyc(1'b0, 1'b1, 2, 32'h0, 32'h0, "R4 enable after clear");
        end

        // R2: masked status under random inputs and masks
        for (int i = 0; i < 64; i++) begin
            cyc(1'b1, 1'b0, 2, $urandom, $urandom, "R2");
            cyc(1'b1, 1'b0, 3, $urandom, $urandom, "R2");
            cyc(1'b0, 1'b1, 0, 32'h0, $urandom, "R2 masked status");
        end

        // R5: software pending bit
        cyc(1'b1, 1'b0, 3, 32'hFFFF_FFFF, 32'h0, "R5");
        cyc(1'b1, 1'b0, 4, 32'h0, 32'h0, "R5");
        cyc(1'b0, 1'b1, 4, 32'h0, 32'h0, "R5 zero set ignored");
        cyc(1'b1, 1'b0, 4, 32'h0000_0100, 32'h0, "R5");
        cyc(1'b0, 1'b1, 4, 32'h0, 32'hFFFF_FFFE, "R5 soft set read");
        cyc(1'b0, 1'b1, 1, 32'h0, 32'h0, "R5 soft in raw bit 0");
        cyc(1'b1, 1'b0, 2, 32'h1, 32'h0, "R5 soft raises combined");
        cyc(1'b1, 1'b0, 5, 32'h0, 32'h0, "R5");
        cyc(1'b0, 1'b1, 0, 32'h0, 32'h0, "R5 zero clear ignored");
        cyc(1'b1, 1'b0, 5, 32'h8000_0000, 32'h0, "R5");
        cyc(1'b0, 1'b1, 4, 32'h0, 32'h1, "R5 soft cleared");
        cyc(1'b0, 1'b1, 4, 32'h0, 32'hFFFF_FFFF, "R5 input bit 0 only");
        cyc(1'b1, 1'b0, 3, 32'hFFFF_FFFF, 32'h0, "R5");

        // R6: passthrough enable
        cyc(1'b1, 1'b0, 8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
        cyc(1'b0, 1'b1, 8, 32'h0, 32'hFFFF_FFFF, "R6 set masked to 30:21");
        for (int i = 21; i <= 30; i++) begin
            cyc(1'b1, 1'b0, 9, 32'h1 << i, 32'hFFFF_FFFF, "R6");
            cyc(1'b0, 1'b1, 8, 32'h0, 32'hFFFF_FFFF, "R6 clear one bit");
        end
        for (int i = 0; i < 32; i++) begin
            cyc(1'b1, 1'b0, 8, 32'h1 << i, 32'hFFFF_FFFF, "R6");
            cyc(1'b0, 1'b1, 8, 32'h0, 32'hFFFF_FFFF, "R6 single set");
        end

        // R8: every source one-hot with passthrough on, then off
        for (int i = 0; i < 32; i++) idle(32'h1 << i, "R8");
        cyc(1'b1, 1'b0, 9, 32'hFFFF_FFFF, 32'h0, "R8");
        for (int i = 0; i < 32; i++) idle(32'h1 << i, "R8");

        // R9: sweep every index; write all ones where nothing is defined
        for (int i = 0; i < 1024; i++) begin
            if (!(i inside {2, 3, 4, 5, 8, 9}))
                cyc(1'b1, 1'b0, i, 32'hFFFF_FFFF, 32'hA5A5_5A5A, "R9");
            cyc(1'b0, 1'b1, i, 32'h0, 32'hA5A5_5A5A, "R9 index sweep read");
        end
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1, i, 32'h0, 32'h0, "R9 state untouched");

        // Mixed random traffic, including same-cycle read and write
        for (int i = 0; i < 4000; i++) begin
            int unsigned sel;
            logic [31:0] d;
            sel = $urandom_range(11, 0);
            d   = ($urandom_range(3, 0) == 0) ? 32'h0 : $urandom;
            cyc(1'($urandom), 1'($urandom), int'(sel), d, $urandom, "R9 mixed traffic");
        end

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule